// File: doc/BRIEF.md
# Configurable Ethernet PHY status LED driver

This block drives one status LED of an Ethernet transceiver. A four-bit display code picks what the LED shows. It can show a line-state level: speed, link or duplex. It can show a traffic event: transmit, receive, collision, or activity, where activity means transmit or receive. It can show a forced test pattern: steady on, steady off, a fast square wave or a slow square wave. It can also show a combined indication, in which a primary level holds the LED lit and a secondary event flips it. The status inputs are sampled once per clock. A small configuration port loads the display code, a two-bit hold-length code and a global hold enable.

Short traffic events are lengthened so that a person can see them. Each event starts a hold window of 30, 60 or 100 ms, and a new event during the window starts it again. All timing comes from a millisecond strobe, which is produced by dividing the system clock by a parameter. The combined indications always use hold windows, whatever the global enable says. Their windows alternate with an equal quiet gap, so steady traffic still shows as visible blinking.

Top module: `phy_led_driver`

## Requirements
- R1: After reset the LED is off. The display code is 0010 (receive), the hold-length code is 00 and the hold enable is 1, so a single receive event lights the LED for the 30 ms window.
- R2: Display codes 0000, 0100 and 0101 show the speed (1 = 100 Mb/s), link and full-duplex inputs as levels. The LED follows an input change two clocks after the input is sampled.
- R3: Display codes 0001, 0010, 0011 and 0111 show transmit, receive, collision and activity (transmit or receive).
- R4: With the hold enable at 1, an event keeps its LED indication active for between N−1 and N millisecond strobes. N is 30 for hold-length code 00, 60 for 01, and 100 for both 10 and 11.
- R5: An event that arrives while a hold window is open restarts the full window.
- R6: With the hold enable at 0, the single-event displays pass events straight through. A one-clock event lights the LED for exactly one clock.
- R7: Code 1000 forces the LED on and code 1001 forces it off. The unused codes 0110 and 1111 keep it off.
- R8: Code 1010 gives a square wave of exactly 100 ms per half period. Code 1011 gives one of exactly 500 ms per half period.
- R9: The combined codes show the primary level XOR an open secondary window. Code 1100 uses link and receive. Code 1101 uses link and activity, so activity lights the LED even when the link is down. Code 1110 uses full duplex and collision.
- R10: The combined codes apply their hold window even when the hold enable is 0.
- R11: In the combined codes, a secondary window is followed by an equal gap in which events are ignored. Steady secondary traffic therefore makes the LED blink.
- R12: With the ACTIVE_LOW parameter set to 1, the output is the exact inverse of the default polarity, including during and right after reset.
- R13: A configuration write takes effect on the clock edge where cfg_wr is 1. Values on the configuration inputs while cfg_wr is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Load strobe for the configuration fields |
| cfg_mode_i | input | 4 | Display code |
| cfg_hold_sel_i | input | 2 | Hold-length code |
| cfg_hold_en_i | input | 1 | Global hold enable for the single-event displays |
| speed_i | input | 1 | 1 = 100 Mb/s |
| tx_i | input | 1 | Transmit event in this cycle |
| rx_i | input | 1 | Receive event in this cycle |
| col_i | input | 1 | Collision event in this cycle |
| link_i | input | 1 | Link up |
| fdx_i | input | 1 | Full duplex |
| led_o | output | 1 | LED drive, polarity set by ACTIVE_LOW |

## Verification
The hardest behaviour to reach is in the combined displays, where the window and the following gap interact. A single pulse only shows one window closing back onto the primary level. The gap can only be seen through the LED if the secondary event is held high for many windows with the link up. The bench does exactly that, and checks that the LED keeps changing instead of staying dark. It also reaches the restart case by placing a second event half-way through an open window. It then confirms that the LED is still lit after the first window would have closed, and dark one full window after the second event.

// File: rtl/led_pkg.sv
package led_pkg;

    typedef enum logic [3:0] {
        LM_SPEED    = 4'h0,
        LM_TX       = 4'h1,
        LM_RX       = 4'h2,
        LM_COL      = 4'h3,
        LM_LINK     = 4'h4,
        LM_DUPLEX   = 4'h5,
        LM_RSVD6    = 4'h6,
        LM_ACT      = 4'h7,
        LM_ON       = 4'h8,
        LM_OFF      = 4'h9,
        LM_FAST     = 4'hA,
        LM_SLOW     = 4'hB,
        LM_LINK_RX  = 4'hC,
        LM_LINK_ACT = 4'hD,
        LM_DUP_COL  = 4'hE,
        LM_RSVD15   = 4'hF
    } led_mode_e;

    typedef struct packed {
        led_mode_e  mode;
        logic [1:0] hold_sel;
        logic       hold_en;
    } led_cfg_t;

    localparam led_cfg_t CFG_RST = '{mode: LM_RX, hold_sel: 2'b00, hold_en: 1'b1};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_GAP  = 2'd2
    } str_state_e;

    typedef struct packed {
        led_cfg_t cfg;
        logic     spd;
        logic     lnk;
        logic     fdx;
        logic     led;
    } led_top_t;

    // stretcher channel indices
    localparam int CH_TX    = 0;
    localparam int CH_RX    = 1;
    localparam int CH_COL   = 2;
    localparam int CH_ACT   = 3;
    localparam int CH_B_RX  = 4;
    localparam int CH_B_ACT = 5;
    localparam int CH_B_COL = 6;
    localparam int NCH      = 7;

endpackage

// File: rtl/led_ms_tick.sv
module led_ms_tick #(
    parameter int CLK_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = $clog2(CLK_PER_MS + 1);
    localparam logic [W-1:0] LAST = W'(CLK_PER_MS - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);

    // R8
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CLK_PER_MS > 1 && tick_o) |=> !tick_o);

endmodule

// File: rtl/led_square.sv
module led_square #(
    parameter int HALF_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic wave_o
);
    localparam int W = $clog2(HALF_MS + 1);
    localparam logic [W-1:0] LAST = W'(HALF_MS - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         wave;
    } sq_t;

    sq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick_i) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt  = '0;
                s_d.wave = ~s_q.wave;
            end else begin
                s_d.cnt = s_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wave_o = s_q.wave;

    // R8
    wave_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.wave) |-> $past(tick_i));

endmodule

// File: rtl/led_stretch.sv
module led_stretch
    import led_pkg::*;
#(
    parameter int DUR_W   = 7,
    parameter bit HAS_GAP = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic             evt_i,
    output logic             out_o
);
    typedef struct packed {
        str_state_e       st;
        logic [DUR_W-1:0] cnt;
        logic             out;
    } str_t;

    str_t s_d, s_q;
    logic stretch_on;

    assign stretch_on = en_i | HAS_GAP;

    always_comb begin
        s_d = s_q;
        if (!stretch_on) begin
            s_d.st  = ST_IDLE;
            s_d.cnt = '0;
            s_d.out = evt_i;
        end else begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (evt_i) begin
                        s_d.st  = ST_HOLD;
                        s_d.cnt = dur_i;
                    end
                end
                ST_HOLD: begin
                    if (evt_i && !HAS_GAP) begin
                        s_d.cnt = dur_i;
                    end else if (tick_i) begin
                        if (s_q.cnt <= DUR_W'(1)) begin
                            if (HAS_GAP) begin
                                s_d.st  = ST_GAP;
                                s_d.cnt = dur_i;
                            end else begin
                                s_d.st  = ST_IDLE;
                                s_d.cnt = '0;
                            end
                        end else begin
                            s_d.cnt = s_q.cnt - DUR_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (tick_i) begin
                        if (s_q.cnt <= DUR_W'(1)) begin
                            s_d.st  = ST_IDLE;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = s_q.cnt - DUR_W'(1);
                        end
                    end
                end
                default: begin
                    s_d.st  = ST_IDLE;
                    s_d.cnt = '0;
                end
            endcase
            s_d.out = (s_d.st == ST_HOLD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0, out: 1'b0};
        else        s_q <= s_d;
    end

    assign out_o = s_q.out;

    // R4
    window_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE) |-> (s_q.cnt != '0));

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_GAP && en_i && evt_i) |=> (s_q.st == ST_HOLD && s_q.cnt == $past(dur_i)));

    // R11
    gap_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_GAP && s_q.st == ST_GAP && !tick_i) |=> (s_q.st == ST_GAP && !out_o));

    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !HAS_GAP) |=> (out_o == $past(evt_i)));

endmodule

// File: rtl/phy_led_driver.sv
module phy_led_driver
    import led_pkg::*;
#(
    parameter int CLK_PER_MS    = 125000,
    parameter int HOLD_SHORT_MS = 30,
    parameter int HOLD_MID_MS   = 60,
    parameter int HOLD_LONG_MS  = 100,
    parameter int FAST_HALF_MS  = 100,
    parameter int SLOW_HALF_MS  = 500,
    parameter bit ACTIVE_LOW    = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [3:0] cfg_mode_i,
    input  logic [1:0] cfg_hold_sel_i,
    input  logic       cfg_hold_en_i,
    input  logic       speed_i,
    input  logic       tx_i,
    input  logic       rx_i,
    input  logic       col_i,
    input  logic       link_i,
    input  logic       fdx_i,
    output logic       led_o
);
    localparam int DUR_W = $clog2(HOLD_LONG_MS + 1);
    localparam logic [NCH-1:0] GAP_MASK = 7'b111_0000;
    localparam logic LED_ON  = ~ACTIVE_LOW;
    localparam logic LED_OFF = ACTIVE_LOW;

    led_top_t r_d, r_q;

    logic             tick_w;
    logic             fast_w, slow_w;
    logic [DUR_W-1:0] dur_w;
    logic [NCH-1:0]   evt_w, str_w;
    logic             act_w;
    logic             lit_w;

    led_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
    );

    led_square #(.HALF_MS(FAST_HALF_MS)) u_fast (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .wave_o(fast_w)
    );

    led_square #(.HALF_MS(SLOW_HALF_MS)) u_slow (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .wave_o(slow_w)
    );

    always_comb begin
        case (r_q.cfg.hold_sel)
            2'b00:   dur_w = DUR_W'(HOLD_SHORT_MS);
            2'b01:   dur_w = DUR_W'(HOLD_MID_MS);
            default: dur_w = DUR_W'(HOLD_LONG_MS);
        endcase
    end

    assign act_w = tx_i | rx_i;

    always_comb begin
        evt_w           = '0;
        evt_w[CH_TX]    = tx_i;
        evt_w[CH_RX]    = rx_i;
        evt_w[CH_COL]   = col_i;
        evt_w[CH_ACT]   = act_w;
        evt_w[CH_B_RX]  = rx_i;
        evt_w[CH_B_ACT] = act_w;
        evt_w[CH_B_COL] = col_i;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        led_stretch #(
            .DUR_W  (DUR_W),
            .HAS_GAP(GAP_MASK[g])
        ) u_str (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(tick_w),
            .en_i  (r_q.cfg.hold_en),
            .dur_i (dur_w),
            .evt_i (evt_w[g]),
            .out_o (str_w[g])
        );
    end

    always_comb begin
        case (r_q.cfg.mode)
            LM_SPEED:    lit_w = r_q.spd;
            LM_TX:       lit_w = str_w[CH_TX];
            LM_RX:       lit_w = str_w[CH_RX];
            LM_COL:      lit_w = str_w[CH_COL];
            LM_LINK:     lit_w = r_q.lnk;
            LM_DUPLEX:   lit_w = r_q.fdx;
            LM_ACT:      lit_w = str_w[CH_ACT];
            LM_ON:       lit_w = 1'b1;
            LM_OFF:      lit_w = 1'b0;
            LM_FAST:     lit_w = fast_w;
            LM_SLOW:     lit_w = slow_w;
            LM_LINK_RX:  lit_w = r_q.lnk ^ str_w[CH_B_RX];
            LM_LINK_ACT: lit_w = r_q.lnk ^ str_w[CH_B_ACT];
            LM_DUP_COL:  lit_w = r_q.fdx ^ str_w[CH_B_COL];
            default:     lit_w = 1'b0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (cfg_wr) begin
            r_d.cfg.mode     = led_mode_e'(cfg_mode_i);
            r_d.cfg.hold_sel = cfg_hold_sel_i;
            r_d.cfg.hold_en  = cfg_hold_en_i;
        end
        r_d.spd = speed_i;
        r_d.lnk = link_i;
        r_d.fdx = fdx_i;
        r_d.led = lit_w ? LED_ON : LED_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cfg: CFG_RST, spd: 1'b0, lnk: 1'b0, fdx: 1'b0, led: LED_OFF};
        else        r_q <= r_d;
    end

    assign led_o = r_q.led;

    // R13
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(r_q.cfg));

    // R7
    force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cfg.mode == LM_ON) |=> (led_o == LED_ON));

    // R7
    unused_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cfg.mode == LM_RSVD6 || r_q.cfg.mode == LM_RSVD15) |=> (led_o == LED_OFF));

    // R9
    primary_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cfg.mode == LM_LINK_RX && !str_w[CH_B_RX])
            |=> (led_o == ($past(r_q.lnk) ? LED_ON : LED_OFF)));

endmodule

// File: tb/sim_phy_led_driver.sv
`timescale 1ns/1ps
module sim_phy_led_driver;

    localparam int P = 4;   // clocks per millisecond strobe in this bench
    localparam int NV = 25;

    // vector: [10:7] code, [6] speed, [5] tx, [4] rx, [3] col, [2] link, [1] fdx, [0] expected LED
    localparam logic [10:0] VEC [NV] = '{
        11'b1100_0000101, 11'b1100_0000000, 11'b1101_0000101, 11'b1101_0000000,
        11'b1110_0000011, 11'b1110_0000100,
        11'b0000_1000001, 11'b0000_0000100, 11'b0100_0000101, 11'b0100_0000010,
        11'b0101_0000011, 11'b0101_0000100,
        11'b0001_0100001, 11'b0001_0010000, 11'b0010_0010001, 11'b0010_0100000,
        11'b0011_0001001, 11'b0011_0110000, 11'b0111_0100001, 11'b0111_0010001,
        11'b0111_0000000, 11'b1000_0000001, 11'b1001_1111110, 11'b0110_1111110,
        11'b1111_1111110
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_mode_i = 4'h0;
    logic [1:0] cfg_hold_sel_i = 2'b00;
    logic       cfg_hold_en_i = 1'b0;
    logic       speed_i = 1'b0, tx_i = 1'b0, rx_i = 1'b0, col_i = 1'b0;
    logic       link_i = 1'b0, fdx_i = 1'b0;
    logic       led, led_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phy_led_driver #(.CLK_PER_MS(P)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode_i(cfg_mode_i),
        .cfg_hold_sel_i(cfg_hold_sel_i), .cfg_hold_en_i(cfg_hold_en_i),
        .speed_i(speed_i), .tx_i(tx_i), .rx_i(rx_i), .col_i(col_i),
        .link_i(link_i), .fdx_i(fdx_i), .led_o(led)
    );

    phy_led_driver #(.CLK_PER_MS(P), .ACTIVE_LOW(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode_i(cfg_mode_i),
        .cfg_hold_sel_i(cfg_hold_sel_i), .cfg_hold_en_i(cfg_hold_en_i),
        .speed_i(speed_i), .tx_i(tx_i), .rx_i(rx_i), .col_i(col_i),
        .link_i(link_i), .fdx_i(fdx_i), .led_o(led_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [3:0] m, input logic [1:0] s, input logic e);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode_i = m; cfg_hold_sel_i = s; cfg_hold_en_i = e;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic quiet();
        @(negedge clk);
        speed_i = 0; tx_i = 0; rx_i = 0; col_i = 0; link_i = 0; fdx_i = 0;
    endtask

    // which: 0 transmit, 1 receive, 2 collision; one clock wide
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tx_i = 1'b1;
            1: rx_i = 1'b1;
            default: col_i = 1'b1;
        endcase
        @(negedge clk);
        tx_i = 1'b0; rx_i = 1'b0; col_i = 1'b0;
    endtask

    // called right after pulse(): level lvl until N-1 strobes, opposite after N
    task automatic stretch_check(input int n, input string tag, input logic lvl);
        edges((n - 1) * P + 1);
        chk(tag, led, lvl);
        edges(P);
        chk(tag, led, ~lvl);
    endtask

    task automatic half_period(output int len);
        logic prev;
        int guard;
        edges(1);
        prev = led;
        guard = 0;
        while (led == prev && guard < 5000) begin
            edges(1);
            guard++;
        end
        prev = led;
        len = 0;
        do begin
            edges(1);
            len++;
        end while (led == prev && len < 5000);
    endtask

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'h0, 4'h4, 4'h5:        return "R2";
            4'h1, 4'h2, 4'h3, 4'h7:  return "R3";
            4'hC, 4'hD, 4'hE:        return "R9";
            default:                 return "R7";
        endcase
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        int len;
        int changes;
        logic prev;

        // reset state
        edges(5);
        @(negedge clk);
        rst_n = 1'b1;
        edges(2);
        chk("R1", led, 1'b0);
        chk("R12", led_n, 1'b1);
        // reset configuration: receive display, 30 ms, hold on
        pulse(1);
        stretch_check(30, "R1", 1'b1);

        // vector table, hold enable off
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            speed_i = VEC[i][6]; tx_i = VEC[i][5]; rx_i = VEC[i][4];
            col_i = VEC[i][3]; link_i = VEC[i][2]; fdx_i = VEC[i][1];
            write_cfg(VEC[i][10:7], 2'b00, 1'b0);
            edges(3);
            chk(tag_of(VEC[i][10:7]), led, VEC[i][0]);
            chk("R12", led_n, ~VEC[i][0]);
        end
        quiet();

        // R4 hold lengths
        write_cfg(4'h1, 2'b01, 1'b1);
        edges(1000);
        pulse(0);
        stretch_check(60, "R4", 1'b1);
        write_cfg(4'h3, 2'b10, 1'b1);
        edges(1000);
        pulse(2);
        stretch_check(100, "R4", 1'b1);
        write_cfg(4'h7, 2'b11, 1'b1);
        edges(1000);
        pulse(1);
        stretch_check(100, "R4", 1'b1);

        // R5 restart of an open window
        write_cfg(4'h2, 2'b00, 1'b1);
        edges(1000);
        pulse(1);
        edges(60);
        pulse(1);
        edges(60);
        chk("R5", led, 1'b1);
        edges(57);
        chk("R5", led, 1'b1);
        edges(4);
        chk("R5", led, 1'b0);

        // R6 pass-through with hold disabled
        write_cfg(4'h1, 2'b00, 1'b0);
        edges(1000);
        pulse(0);
        edges(1);
        chk("R6", led, 1'b1);
        edges(1);
        chk("R6", led, 1'b0);

        // R10 combined display stays held with enable off
        @(negedge clk);
        link_i = 1'b1;
        write_cfg(4'hC, 2'b00, 1'b0);
        edges(1000);
        chk("R10", led, 1'b1);
        pulse(1);
        stretch_check(30, "R10", 1'b0);

        // R9 link plus activity with link down
        quiet();
        write_cfg(4'hD, 2'b01, 1'b1);
        edges(1000);
        pulse(0);
        stretch_check(60, "R9", 1'b1);

        // R9 duplex plus collision
        @(negedge clk);
        fdx_i = 1'b1;
        write_cfg(4'hE, 2'b10, 1'b1);
        edges(1000);
        pulse(2);
        stretch_check(100, "R9", 1'b0);
        quiet();

        // R11 steady secondary traffic keeps blinking
        @(negedge clk);
        link_i = 1'b1;
        rx_i = 1'b1;
        write_cfg(4'hC, 2'b00, 1'b1);
        edges(2);
        prev = led;
        changes = 0;
        for (int k = 0; k < 1200; k++) begin
            edges(1);
            if (led != prev) changes++;
            prev = led;
        end
        chk("R11", (changes >= 4), 1'b1);
        quiet();

        // R8 test square waves
        write_cfg(4'hA, 2'b00, 1'b1);
        half_period(len);
        chk("R8", (len == 100 * P), 1'b1);
        if (len != 100 * P) $display("FAIL R8: actual %0d expected %0d", len, 100 * P);
        write_cfg(4'hB, 2'b00, 1'b1);
        half_period(len);
        chk("R8", (len == 500 * P), 1'b1);
        if (len != 500 * P) $display("FAIL R8: actual %0d expected %0d", len, 500 * P);

        // R13 inputs ignored without the load strobe
        write_cfg(4'h2, 2'b00, 1'b1);
        edges(1000);
        @(negedge clk);
        cfg_mode_i = 4'h8;
        edges(4);
        chk("R13", led, 1'b0);
        chk("R12", led_n, 1'b1);
        write_cfg(4'h8, 2'b00, 1'b1);
        edges(1);
        chk("R13", led, 1'b1);
        chk("R12", led_n, 1'b0);

        finish_run();
    end

endmodule